// File: doc/BRIEF.md
# Ownership-Change Interrupt Router

This unit keeps the interrupt status of a host controller and turns it into two level outputs: an ordinary interrupt line and a system-management interrupt (SMI) line. One status bit records a change of controller ownership. The other status bits record events from generic hardware sources. Software asks for an ownership handover by writing a one to a request bit in the command register. One cycle later that request latches the ownership-change status bit. As a result, an interrupt is raised each time control passes between the operating-system driver and a driver running in system-management mode.

Each status bit has an enable bit of its own. A master enable gates both outputs. A routing control steers the generic sources to either line. The ownership-change source ignores the routing control and always targets the SMI line. When the build parameter says no SMI pin exists, the ownership-change source raises nothing at all. Status bits clear when software writes a one to them.

Status layout: bits `GEN_SRCS-1:0` belong to the generic sources and bit `GEN_SRCS` is the ownership-change bit. Enable bits use the same positions.

Top module: `own_irq_router`

## Requirements
- R1: After a synchronous reset, the request bit, every status bit, every enable bit, the master enable, the routing control, `irq_o` and `smi_o` all read 0.
- R2: A command write with `cmd_own_req`=1 makes `own_req_o` read 1 in the next cycle. The bit clears by itself one cycle later unless the write repeats. A command write with `cmd_own_req`=0 leaves `own_req_o` at 0.
- R3: While `own_req_o` is 1, the next clock edge sets status bit `GEN_SRCS` (ownership change).
- R4: A status write clears each status bit whose `sts_wdata` bit is 1 and leaves bits written with 0 unchanged. If a set and a clear hit the same bit in one cycle, the set wins.
- R5: A pulse on `src_event[i]` sets status bit i at that clock edge.
- R6: A pending generic source (status and enable bit both 1) drives `irq_o` when the routing control is 0 and `smi_o` when it is 1. The outputs are registered and follow the stored state one edge later. With no SMI pin, generic sources routed to SMI raise nothing.
- R7: A pending ownership-change source (status bit `GEN_SRCS` and its enable both 1) drives `smi_o` whatever the routing control is, and never drives `irq_o`.
- R8: While the master enable is 0, both `irq_o` and `smi_o` are 0 one edge after the enable is stored.
- R9: A source whose enable bit is 0 contributes to neither output. The enable register loads `en_wdata` on an enable write.
- R10: With `HAS_SMI`=0, `smi_o` stays 0 and an ownership-change status bit never asserts `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_own_req | input | 1 | Ownership-change request bit of the command write |
| sts_wr | input | 1 | Status register write strobe (write one to clear) |
| sts_wdata | input | GEN_SRCS+1 | Status bits to clear |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | GEN_SRCS+1 | New per-source enable bits |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_master_en | input | 1 | New master enable |
| ctl_route_smi | input | 1 | New routing control (1 = generic sources to SMI) |
| src_event | input | GEN_SRCS | Generic source event pulses |
| own_req_o | output | 1 | Ownership-change request bit readback |
| sts_o | output | GEN_SRCS+1 | Status bits |
| en_o | output | GEN_SRCS+1 | Enable bits |
| master_en_o | output | 1 | Master enable readback |
| route_smi_o | output | 1 | Routing control readback |
| irq_o | output | 1 | Normal interrupt line (level) |
| smi_o | output | 1 | System-management interrupt line (level) |

## Verification
The bench builds two instances side by side. The first has `GEN_SRCS`=2 and `HAS_SMI`=1, which exercises the routing of generic sources to either line, ownership-change delivery to SMI under both routing settings, and a status vector wider than one generic bit. The second has `GEN_SRCS`=1 and `HAS_SMI`=0 and receives the same stimulus, so it shows under identical events that the ownership-change source stays silent without an SMI pin. It also shows that generic sources still reach `irq_o` when the routing control is 0.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef struct packed {
    logic master_en;
    logic route_smi;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{master_en: 1'b0, route_smi: 1'b0};

endpackage

// File: rtl/oc_cmd_reg.sv
module oc_cmd_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic req_bit,
  output logic req_q
);

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= wr & req_bit;
  end

  // R2: the request bit is a one-cycle pulse unless rewritten
  assert_req_self_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (req_q && !(wr && req_bit)) |=> !req_q);

  assert_req_zero_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && !req_bit) |=> !req_q);

endmodule

// File: rtl/oc_status_reg.sv
module oc_status_reg #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_vec,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] sts_q
);

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic clr_i;
    assign clr_i = clr_wr & clr_mask[i];

    always_ff @(posedge clk) begin
      if (rst)             sts_q[i] <= 1'b0;
      else if (set_vec[i]) sts_q[i] <= 1'b1;
      else if (clr_i)      sts_q[i] <= 1'b0;
    end

    // R4: write one clears when no set collides
    assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !set_vec[i]) |=> !sts_q[i]);

    // R4: no set and no clear keeps the bit
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!clr_i && !set_vec[i]) |=> (sts_q[i] == $past(sts_q[i])));

    // R3/R5: a set always lands, even against a clear
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> sts_q[i]);
  end

endmodule

// File: rtl/oc_enable_reg.sv
module oc_enable_reg
  import oc_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_wdata,
  input  logic            ctl_wr,
  input  logic            ctl_master_en,
  input  logic            ctl_route_smi,
  output logic [NSRC-1:0] en_q,
  output ctrl_t           ctrl_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      ctrl_q <= CTRL_RESET;
    end else begin
      if (en_wr)  en_q <= en_wdata;
      if (ctl_wr) begin
        ctrl_q.master_en <= ctl_master_en;
        ctrl_q.route_smi <= ctl_route_smi;
      end
    end
  end

  // R9: enable register loads the written value
  assert_en_load_R9: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> (en_q == $past(en_wdata)));

endmodule

// File: rtl/oc_route.sv
module oc_route
  import oc_pkg::*;
#(
  parameter int GEN_SRCS = 2,
  parameter bit HAS_SMI  = 1'b1,
  localparam int NSRC    = GEN_SRCS + 1,
  localparam int OC_BIT  = GEN_SRCS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] sts,
  input  logic [NSRC-1:0] en,
  input  ctrl_t           ctrl,
  output logic            irq_o,
  output logic            smi_o
);

  logic gen_pend;
  logic oc_pend;
  logic irq_d;

  assign gen_pend = |(sts[GEN_SRCS-1:0] & en[GEN_SRCS-1:0]);
  assign oc_pend  = sts[OC_BIT] & en[OC_BIT];
  assign irq_d    = ctrl.master_en & ~ctrl.route_smi & gen_pend;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= irq_d;
  end

  if (HAS_SMI) begin : g_smi
    logic smi_d;
    assign smi_d = ctrl.master_en & ((ctrl.route_smi & gen_pend) | oc_pend);

    always_ff @(posedge clk) begin
      if (rst) smi_o <= 1'b0;
      else     smi_o <= smi_d;
    end

    // R7: pending ownership change reaches SMI regardless of routing
    assert_oc_to_smi_R7: assert property (@(posedge clk) disable iff (rst)
      (ctrl.master_en && sts[OC_BIT] && en[OC_BIT]) |=> smi_o);
  end else begin : g_no_smi
    assign smi_o = 1'b0;
    logic unused_oc;
    assign unused_oc = oc_pend;
  end

  // R7/R10: the ownership-change bit alone never raises the normal line
  assert_oc_not_irq_R7: assert property (@(posedge clk) disable iff (rst)
    !(|(sts[GEN_SRCS-1:0] & en[GEN_SRCS-1:0])) |=> !irq_o);

  // R8: master enable gates both lines
  assert_master_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !ctrl.master_en |=> (!irq_o && !smi_o));

  // R6: generic sources routed to SMI leave the normal line low
  assert_route_smi_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl.route_smi |=> !irq_o);

endmodule

// File: rtl/own_irq_router.sv
module own_irq_router
  import oc_pkg::*;
#(
  parameter int GEN_SRCS = 2,
  parameter bit HAS_SMI  = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_wr,
  input  logic                cmd_own_req,
  input  logic                sts_wr,
  input  logic [GEN_SRCS:0]   sts_wdata,
  input  logic                en_wr,
  input  logic [GEN_SRCS:0]   en_wdata,
  input  logic                ctl_wr,
  input  logic                ctl_master_en,
  input  logic                ctl_route_smi,
  input  logic [GEN_SRCS-1:0] src_event,
  output logic                own_req_o,
  output logic [GEN_SRCS:0]   sts_o,
  output logic [GEN_SRCS:0]   en_o,
  output logic                master_en_o,
  output logic                route_smi_o,
  output logic                irq_o,
  output logic                smi_o
);

  localparam int NSRC = GEN_SRCS + 1;

  logic            req_q;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] sts_q;
  logic [NSRC-1:0] en_q;
  ctrl_t           ctrl_q;

  oc_cmd_reg u_cmd (
    .clk     (clk),
    .rst     (rst),
    .wr      (cmd_wr),
    .req_bit (cmd_own_req),
    .req_q   (req_q)
  );

  assign set_vec = {req_q, src_event};

  oc_status_reg #(.NSRC(NSRC)) u_sts (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_wr   (sts_wr),
    .clr_mask (sts_wdata),
    .sts_q    (sts_q)
  );

  oc_enable_reg #(.NSRC(NSRC)) u_en (
    .clk           (clk),
    .rst           (rst),
    .en_wr         (en_wr),
    .en_wdata      (en_wdata),
    .ctl_wr        (ctl_wr),
    .ctl_master_en (ctl_master_en),
    .ctl_route_smi (ctl_route_smi),
    .en_q          (en_q),
    .ctrl_q        (ctrl_q)
  );

  oc_route #(.GEN_SRCS(GEN_SRCS), .HAS_SMI(HAS_SMI)) u_route (
    .clk   (clk),
    .rst   (rst),
    .sts   (sts_q),
    .en    (en_q),
    .ctrl  (ctrl_q),
    .irq_o (irq_o),
    .smi_o (smi_o)
  );

  assign own_req_o   = req_q;
  assign sts_o       = sts_q;
  assign en_o        = en_q;
  assign master_en_o = ctrl_q.master_en;
  assign route_smi_o = ctrl_q.route_smi;

  // R3: a pending request lands in the ownership-change status bit
  assert_req_sets_status_R3: assert property (@(posedge clk) disable iff (rst)
    req_q |=> sts_q[GEN_SRCS]);

endmodule

// File: tb/own_irq_router_bench.sv
module own_irq_router_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       cmd_wr = 0, cmd_own_req = 0, sts_wr = 0, en_wr = 0;
  logic       ctl_wr = 0, ctl_master_en = 0, ctl_route_smi = 0;
  logic [2:0] sts_wdata = '0, en_wdata = '0;
  logic [1:0] src_event = '0;

  logic       a_req, a_master, a_route, a_irq, a_smi;
  logic [2:0] a_sts, a_en;
  logic       b_req, b_master, b_route, b_irq, b_smi;
  logic [1:0] b_sts, b_en;

  own_irq_router #(.GEN_SRCS(2), .HAS_SMI(1'b1)) u_own_irq_router (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_own_req(cmd_own_req),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .en_wr(en_wr), .en_wdata(en_wdata),
    .ctl_wr(ctl_wr), .ctl_master_en(ctl_master_en), .ctl_route_smi(ctl_route_smi),
    .src_event(src_event), .own_req_o(a_req), .sts_o(a_sts), .en_o(a_en),
    .master_en_o(a_master), .route_smi_o(a_route), .irq_o(a_irq), .smi_o(a_smi));

  own_irq_router #(.GEN_SRCS(1), .HAS_SMI(1'b0)) u_own_irq_router_nosmi (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_own_req(cmd_own_req),
    .sts_wr(sts_wr), .sts_wdata({sts_wdata[2], sts_wdata[0]}), .en_wr(en_wr),
    .en_wdata({en_wdata[2], en_wdata[0]}), .ctl_wr(ctl_wr),
    .ctl_master_en(ctl_master_en), .ctl_route_smi(ctl_route_smi),
    .src_event(src_event[0]), .own_req_o(b_req), .sts_o(b_sts), .en_o(b_en),
    .master_en_o(b_master), .route_smi_o(b_route), .irq_o(b_irq), .smi_o(b_smi));

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference state computed from the requirements
  logic       m_req, m_master, m_route, m_irq, m_smi, mb_irq;
  logic [2:0] m_sts, m_en;
  logic [1:0] mb_sts, mb_en;

  function automatic logic exp_irq(logic master, logic route, logic [1:0] gp);
    return master & ~route & (|gp);
  endfunction

  function automatic logic exp_smi(logic master, logic route, logic [1:0] gp, logic oc);
    return master & ((route & (|gp)) | oc);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_req <= 0; m_master <= 0; m_route <= 0; m_irq <= 0; m_smi <= 0;
      m_sts <= '0; m_en <= '0; mb_sts <= '0; mb_en <= '0; mb_irq <= 0;
    end else begin
      m_req <= cmd_wr & cmd_own_req;
      for (int i = 0; i < 2; i++)
        m_sts[i] <= src_event[i] | (m_sts[i] & ~(sts_wr & sts_wdata[i]));
      m_sts[2]  <= m_req | (m_sts[2] & ~(sts_wr & sts_wdata[2]));
      mb_sts[0] <= src_event[0] | (mb_sts[0] & ~(sts_wr & sts_wdata[0]));
      mb_sts[1] <= m_req | (mb_sts[1] & ~(sts_wr & sts_wdata[2]));
      if (en_wr) begin
        m_en  <= en_wdata;
        mb_en <= {en_wdata[2], en_wdata[0]};
      end
      if (ctl_wr) begin
        m_master <= ctl_master_en;
        m_route  <= ctl_route_smi;
      end
      m_irq  <= exp_irq(m_master, m_route, m_sts[1:0] & m_en[1:0]);
      m_smi  <= exp_smi(m_master, m_route, m_sts[1:0] & m_en[1:0], m_sts[2] & m_en[2]);
      mb_irq <= exp_irq(m_master, m_route, {1'b0, mb_sts[0] & mb_en[0]});
    end
  end

  // Continuous comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 own_req_o", {7'd0, a_req}, {7'd0, m_req});
      chk("R4 sts_o", {5'd0, a_sts}, {5'd0, m_sts});
      chk("R9 en_o", {5'd0, a_en}, {5'd0, m_en});
      chk("R6 irq_o", {7'd0, a_irq}, {7'd0, m_irq});
      chk("R7 smi_o", {7'd0, a_smi}, {7'd0, m_smi});
      chk("R10 nosmi sts_o", {6'd0, b_sts}, {6'd0, mb_sts});
      chk("R10 nosmi irq_o", {7'd0, b_irq}, {7'd0, mb_irq});
      chk("R10 nosmi smi_o", {7'd0, b_smi}, 8'd0);
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cmd_wr = 0; sts_wr = 0; en_wr = 0; ctl_wr = 0; src_event = '0;
  endtask

  task automatic set_ctl(logic master, logic route);
    ctl_wr = 1; ctl_master_en = master; ctl_route_smi = route;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0C0FFEE1));
    repeat (3) @(negedge clk);
    rst = 0;
    cyc();
    // R1: reset state
    chk("R1 reset a", {a_req, a_sts, a_master, a_route, a_irq, a_smi}, 8'd0);
    chk("R1 reset en", {5'd0, a_en}, 8'd0);
    chk("R1 reset b", {b_req, b_sts, b_master, b_route, b_irq, b_smi, 1'b0}, 8'd0);

    en_wr = 1; en_wdata = 3'b111; set_ctl(1, 0);
    cyc(); idle();
    chk("R9 enable load", {5'd0, a_en}, 8'h07);

    cmd_wr = 1; cmd_own_req = 0;
    cyc(); idle();
    chk("R2 zero write", {7'd0, a_req}, 8'd0);

    cmd_wr = 1; cmd_own_req = 1;
    cyc(); idle();
    chk("R2 request pulse", {7'd0, a_req}, 8'd1);
    chk("R3 not yet set", {7'd0, a_sts[2]}, 8'd0);
    cyc();
    chk("R2 self clear", {7'd0, a_req}, 8'd0);
    chk("R3 status set", {7'd0, a_sts[2]}, 8'd1);
    cyc();
    chk("R7 smi on oc", {6'd0, a_irq, a_smi}, 8'b01);
    chk("R10 nosmi silent", {6'd0, b_irq, b_smi}, 8'b00);
    chk("R3 nosmi status", {7'd0, b_sts[1]}, 8'd1);

    set_ctl(1, 1);
    cyc(); idle(); cyc();
    chk("R7 route ignored", {6'd0, a_irq, a_smi}, 8'b01);

    src_event = 2'b01;
    cyc(); idle();
    chk("R5 event sets", {7'd0, a_sts[0]}, 8'd1);
    cyc();
    chk("R6 generic to smi", {6'd0, a_irq, a_smi}, 8'b01);
    chk("R6 nosmi routed away", {6'd0, b_irq, b_smi}, 8'b00);

    set_ctl(1, 0);
    cyc(); idle(); cyc();
    chk("R6 generic to irq", {6'd0, a_irq, a_smi}, 8'b11);
    chk("R6 nosmi irq", {6'd0, b_irq, b_smi}, 8'b10);

    en_wr = 1; en_wdata = 3'b011;
    cyc(); idle(); cyc();
    chk("R9 oc masked", {6'd0, a_irq, a_smi}, 8'b10);

    sts_wr = 1; sts_wdata = 3'b000;
    cyc(); idle();
    chk("R4 zero write keeps", {5'd0, a_sts}, 8'b101);

    sts_wr = 1; sts_wdata = 3'b001; src_event = 2'b01;
    cyc(); idle();
    chk("R4 set wins", {7'd0, a_sts[0]}, 8'd1);

    sts_wr = 1; sts_wdata = 3'b101;
    cyc(); idle();
    chk("R4 w1c", {5'd0, a_sts}, 8'd0);

    en_wr = 1; en_wdata = 3'b111; src_event = 2'b10; set_ctl(0, 0);
    cyc(); idle(); cyc();
    chk("R8 master off", {6'd0, a_irq, a_smi}, 8'b00);
    chk("R5 second source", {7'd0, a_sts[1]}, 8'd1);

    for (int k = 0; k < 4000; k++) begin
      cmd_wr        = ($urandom % 8) == 0;
      cmd_own_req   = $urandom;
      sts_wr        = ($urandom % 6) == 0;
      sts_wdata     = $urandom;
      en_wr         = ($urandom % 10) == 0;
      en_wdata      = $urandom;
      ctl_wr        = ($urandom % 12) == 0;
      ctl_master_en = ($urandom % 4) != 0;
      ctl_route_smi = $urandom;
      src_event     = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
      cyc();
    end
    idle();
    cyc();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule